// File: doc/BRIEF.md
# Register Rename Map with Deferred Reclamation

This block is the renaming step at the front of decode. It accepts one instruction per cycle, carrying two 5-bit logical source fields, a 5-bit logical destination field and a flag that marks the instruction as a load. It returns the same fields translated to 6-bit physical register names, drawn from a pool of 40 physical registers. A map table holds the current translation for each logical register. Spare physical names wait in a free list.

Only a load gives its destination a new meaning. It takes the oldest spare name from the free list and writes it into the map. The name it displaces is not made free right away. That name waits in a return queue until no in-flight instruction still refers to it and no load data is still due to it. A load's new name also stays marked as awaiting data until a return notice for that name arrives. Any instruction that would read such a name is held at decode. Downstream logic reports each finished operand reference on a separate port, and the block counts these reports per physical name.

Top module: `reg_rename_unit`

## Requirements
- R1: After reset, logical register k maps to physical register k for k = 0..31, so a non-load that reads k gets physical name k on its source outputs.
- R2: After reset the free list holds physical names 32 to 39, oldest first in ascending order. A load takes the oldest free name as its physical destination.
- R3: A load's source fields are translated through the map as it stood before that load, so a load whose source equals its destination reads the displaced name.
- R4: After a load is accepted, every later reference to its logical destination gets the load's new name, until another load to the same destination is accepted.
- R5: A name displaced by a load goes to the tail of a FIFO return queue. From the queue head, at most one name per cycle moves to the tail of the free list, and only once that name has zero outstanding references and no pending load data. This makes it the latest choice for reuse.
- R6: A load's new name is marked as awaiting data. `stall` is high in the same cycle when a valid instruction has a source, or (for a non-load) a destination, whose current name is marked. The instruction is then not accepted.
- R7: A load-data return naming a physical register clears its mark. An instruction held only by that mark is accepted in the next cycle.
- R8: A valid load with an empty free list stalls. Non-loads do not depend on the free list.
- R9: An accepted instruction appears on the outputs one cycle later with `out_valid` high. After an idle or stalled cycle, `out_valid` is low.
- R10: Each accepted instruction adds one reference to the names it reads on source A and on source B, and for a non-load one more to its destination name. Each reference-done report removes one reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction present at decode |
| in_is_load | input | 1 | Instruction class: 1 = load, which renames its destination |
| in_src_a | input | 5 | Logical source A |
| in_src_b | input | 5 | Logical source B |
| in_dst | input | 5 | Logical destination |
| rd_done_valid | input | 1 | One operand reference has finished |
| rd_done_tag | input | 6 | Physical name of the finished reference |
| ld_ret_valid | input | 1 | Load data has come back |
| ld_ret_tag | input | 6 | Physical name whose data came back |
| stall | output | 1 | Instruction cannot be accepted this cycle |
| out_valid | output | 1 | Renamed instruction present |
| out_phys_a | output | 6 | Physical name for source A |
| out_phys_b | output | 6 | Physical name for source B |
| out_phys_d | output | 6 | Physical name for the destination |

## Verification
The assertions assume the environment behaves well. A reference-done report names only a physical register with a nonzero count. A load return names only a register still awaiting data. No name collects more references than its counter can hold. The bench keeps an ordered list of every reference it has caused and reports exactly one per cycle from it. It returns only the oldest names it knows are awaiting data. It issues a new instruction only while fewer than seven references are open, so no count can get near 15. A held instruction stays unchanged on the inputs until it is accepted.

// File: rtl/rnm_pkg.sv
// Package: default sizes shared by the rename block and its bench.
// Assumes the logical register count is a power of two.
package rnm_pkg;
    localparam int RNM_LOG_REGS  = 32;
    localparam int RNM_PHYS_REGS = 40;
    localparam int RNM_REF_CNT_W = 4;
endpackage

// File: rtl/rnm_name_fifo.sv
// Circular FIFO of physical register names. It serves as both the free list
// and the return queue. It can start preloaded with INIT_COUNT consecutive
// names from INIT_BASE. The caller must not pop when empty or push when full
// unless it pops in the same cycle.
module rnm_name_fifo #(
    parameter int W          = 6,
    parameter int DEPTH      = 8,
    parameter int INIT_COUNT = 0,
    parameter int INIT_BASE  = 0,
    localparam int PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);

    // Storage and pointers: preload on reset, then circular push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= (i < INIT_COUNT) ? W'(INIT_BASE + i) : '0;
            rd_ptr <= '0;
            wr_ptr <= PTR_W'(INIT_COUNT % DEPTH);
            count  <= CW'(INIT_COUNT);
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop)
                rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count != CW'(DEPTH)));
endmodule

// File: rtl/rnm_map_table.sv
// Map from logical to physical names. It has three read ports and one write
// port. After reset, logical k maps to physical k. Reads are combinational
// and show the map before any write in the same cycle.
module rnm_map_table #(
    parameter int NUM_LOG = 32,
    parameter int LW      = 5,
    parameter int PW      = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] rd_a,
    input  logic [LW-1:0] rd_b,
    input  logic [LW-1:0] rd_d,
    output logic [PW-1:0] q_a,
    output logic [PW-1:0] q_b,
    output logic [PW-1:0] q_d,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_addr,
    input  logic [PW-1:0] wr_data
);
    logic [PW-1:0] map_q [NUM_LOG];

    assign q_a = map_q[rd_a];
    assign q_b = map_q[rd_b];
    assign q_d = map_q[rd_d];

    // Map state: identity on reset, one entry replaced per accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LOG; i++)
                map_q[i] <= PW'(i);
        end else if (wr_en) begin
            map_q[wr_addr] <= wr_data;
        end
    end
endmodule

// File: rtl/rnm_ref_tracker.sv
// Per-physical-register state. It keeps a count of open operand references
// and a flag for load data still outstanding. Four query ports read this
// state. It assumes done reports and data returns are consistent with the
// state.
module rnm_ref_tracker #(
    parameter int NUM_PHYS = 40,
    parameter int PW       = 6,
    parameter int CNT_W    = 4,
    localparam int CNT_MAX = (1 << CNT_W) - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add_en,
    input  logic [PW-1:0] add_a,
    input  logic [PW-1:0] add_b,
    input  logic          add_d_en,
    input  logic [PW-1:0] add_d,
    input  logic          done_en,
    input  logic [PW-1:0] done_tag,
    input  logic          set_en,
    input  logic [PW-1:0] set_tag,
    input  logic          ret_en,
    input  logic [PW-1:0] ret_tag,
    input  logic [PW-1:0] q_a,
    input  logic [PW-1:0] q_b,
    input  logic [PW-1:0] q_d,
    input  logic [PW-1:0] q_h,
    output logic          pend_a,
    output logic          pend_b,
    output logic          pend_d,
    output logic          idle_h
);
    logic [CNT_W-1:0] cnt_w  [NUM_PHYS];
    logic             pend_w [NUM_PHYS];

    for (genvar p = 0; p < NUM_PHYS; p++) begin : g_ent
        logic [CNT_W-1:0] cnt_r;
        logic             pend_r;
        logic [1:0]       inc;
        logic             dec;

        // Count how many references this entry gains in the current cycle.
        always_comb begin
            inc = 2'(add_en && (add_a == PW'(p)))
                + 2'(add_en && (add_b == PW'(p)))
                + 2'(add_en && add_d_en && (add_d == PW'(p)));
            dec = done_en && (done_tag == PW'(p));
        end

        // Reference counter and awaiting-data flag for this entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_r  <= '0;
                pend_r <= 1'b0;
            end else begin
                cnt_r <= cnt_r + CNT_W'(inc) - CNT_W'(dec);
                if (set_en && (set_tag == PW'(p)))
                    pend_r <= 1'b1;
                else if (ret_en && (ret_tag == PW'(p)))
                    pend_r <= 1'b0;
            end
        end

        assign cnt_w[p]  = cnt_r;
        assign pend_w[p] = pend_r;

        assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ((CNT_W+2)'(cnt_r) + (CNT_W+2)'(inc)) <= ((CNT_W+2)'(CNT_MAX) + (CNT_W+2)'(dec)));
    end

    assign pend_a = pend_w[q_a];
    assign pend_b = pend_w[q_b];
    assign pend_d = pend_w[q_d];
    assign idle_h = (cnt_w[q_h] == '0) && !pend_w[q_h];

    assert_done_has_ref_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_en |-> (cnt_w[done_tag] != '0));
    assert_ret_was_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ret_en |-> pend_w[ret_tag]);
    assert_alloc_not_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !pend_w[set_tag]);
endmodule

// File: rtl/reg_rename_unit.sv
// Rename stage. It translates the source and destination fields of one
// instruction per cycle. A load draws a new physical destination from the
// free list and parks the displaced name in a return queue. A parked name
// goes back to the free list once it has no references and no pending data.
// Decode stalls on names still awaiting load data, and on a load when no
// free name is left. Results are registered one cycle after acceptance.
module reg_rename_unit import rnm_pkg::*; #(
    parameter int  NUM_LOG  = RNM_LOG_REGS,
    parameter int  NUM_PHYS = RNM_PHYS_REGS,
    parameter int  CNT_W    = RNM_REF_CNT_W,
    localparam int LW       = $clog2(NUM_LOG),
    localparam int PW       = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_is_load,
    input  logic [LW-1:0] in_src_a,
    input  logic [LW-1:0] in_src_b,
    input  logic [LW-1:0] in_dst,
    input  logic          rd_done_valid,
    input  logic [PW-1:0] rd_done_tag,
    input  logic          ld_ret_valid,
    input  logic [PW-1:0] ld_ret_tag,
    output logic          stall,
    output logic          out_valid,
    output logic [PW-1:0] out_phys_a,
    output logic [PW-1:0] out_phys_b,
    output logic [PW-1:0] out_phys_d
);
    localparam int SPARE = NUM_PHYS - NUM_LOG;
    localparam int FCW   = $clog2(SPARE + 1);

    logic [PW-1:0]  map_a, map_b, map_d;
    logic [PW-1:0]  free_head, ret_head, new_d;
    logic [FCW-1:0] free_cnt, ret_cnt;
    logic           free_empty, ret_empty;
    logic           pend_a, pend_b, pend_d, head_idle;
    logic           accept, accept_load, release_name;

    rnm_map_table #(.NUM_LOG(NUM_LOG), .LW(LW), .PW(PW)) u_map (
        .clk(clk), .rst_n(rst_n),
        .rd_a(in_src_a), .rd_b(in_src_b), .rd_d(in_dst),
        .q_a(map_a), .q_b(map_b), .q_d(map_d),
        .wr_en(accept_load), .wr_addr(in_dst), .wr_data(free_head)
    );

    rnm_name_fifo #(.W(PW), .DEPTH(SPARE), .INIT_COUNT(SPARE), .INIT_BASE(NUM_LOG)) u_free (
        .clk(clk), .rst_n(rst_n),
        .push(release_name), .push_data(ret_head), .pop(accept_load),
        .head(free_head), .count(free_cnt), .empty(free_empty)
    );

    rnm_name_fifo #(.W(PW), .DEPTH(SPARE), .INIT_COUNT(0), .INIT_BASE(0)) u_ret (
        .clk(clk), .rst_n(rst_n),
        .push(accept_load), .push_data(map_d), .pop(release_name),
        .head(ret_head), .count(ret_cnt), .empty(ret_empty)
    );

    rnm_ref_tracker #(.NUM_PHYS(NUM_PHYS), .PW(PW), .CNT_W(CNT_W)) u_refs (
        .clk(clk), .rst_n(rst_n),
        .add_en(accept), .add_a(map_a), .add_b(map_b),
        .add_d_en(!in_is_load), .add_d(map_d),
        .done_en(rd_done_valid), .done_tag(rd_done_tag),
        .set_en(accept_load), .set_tag(free_head),
        .ret_en(ld_ret_valid), .ret_tag(ld_ret_tag),
        .q_a(map_a), .q_b(map_b), .q_d(map_d), .q_h(ret_head),
        .pend_a(pend_a), .pend_b(pend_b), .pend_d(pend_d), .idle_h(head_idle)
    );

    // Decode hazards, acceptance and reclamation decisions for this cycle.
    always_comb begin
        stall = in_valid && (pend_a || pend_b
                             || (!in_is_load && pend_d)
                             || (in_is_load && free_empty));
        accept       = in_valid && !stall;
        accept_load  = accept && in_is_load;
        release_name = !ret_empty && head_idle;
        new_d        = in_is_load ? free_head : map_d;
    end

    // Output register: renamed fields one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_phys_a <= '0;
            out_phys_b <= '0;
            out_phys_d <= '0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_phys_a <= map_a;
                out_phys_b <= map_b;
                out_phys_d <= new_d;
            end
        end
    end

    assert_names_conserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(free_cnt) + int'(ret_cnt)) == SPARE);
    assert_load_gets_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_is_load && !stall) |=> (out_valid && (out_phys_d == $past(free_head))));
    assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !out_valid);
endmodule

// File: tb/test_reg_rename_unit.sv
`timescale 1ns/1ps
// Bench: directed sweeps, then long constrained-random runs, all checked
// cycle by cycle against a model built from the requirements.
module test_reg_rename_unit;
    localparam int NL = 32;
    localparam int NP = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_is_load = 1'b0;
    logic [4:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
    logic       rd_done_valid = 1'b0, ld_ret_valid = 1'b0;
    logic [5:0] rd_done_tag = '0, ld_ret_tag = '0;
    logic       stall, out_valid;
    logic [5:0] out_phys_a, out_phys_b, out_phys_d;

    always #2 clk = ~clk;

    reg_rename_unit i_reg_rename_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_load(in_is_load),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
        .rd_done_valid(rd_done_valid), .rd_done_tag(rd_done_tag),
        .ld_ret_valid(ld_ret_valid), .ld_ret_tag(ld_ret_tag),
        .stall(stall), .out_valid(out_valid),
        .out_phys_a(out_phys_a), .out_phys_b(out_phys_b), .out_phys_d(out_phys_d)
    );

    int checks = 0, fails = 0;
    int mmap [NL];
    int cnt [NP];
    bit pend [NP];
    bit reused [NP];
    int flq[$], prq[$], refq[$], pendq[$];
    bit exp_ov = 0;
    int exp_pa, exp_pb, exp_pd;
    string lab_a, lab_d;
    bit hold = 0, was_stalled = 0, h_ld = 0;
    int ha, hb, hd;
    int load_pct = 40, ret_pct = 30;

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NL; i++) mmap[i] = i;
        for (int i = 0; i < NP; i++) begin cnt[i] = 0; pend[i] = 0; reused[i] = 0; end
        flq = {}; prq = {}; refq = {}; pendq = {};
        for (int i = NL; i < NP; i++) flq.push_back(i);
    endtask

    // One clock: check outputs, drive inputs, check stall, advance the model.
    task automatic step(input bit want_new);
        bit exp_st, acc, rel, pend_hit;
        int ma, mb, md, newp, rtag, dtag;
        @(negedge clk);
        chk("R9 out_valid", out_valid, exp_ov);
        if (exp_ov) begin
            chk(lab_a, out_phys_a, exp_pa);
            chk(lab_a, out_phys_b, exp_pb);
            chk(lab_d, out_phys_d, exp_pd);
        end
        if (!hold && want_new && refq.size() < 7) begin
            hold = 1;
            h_ld = (($urandom % 100) < load_pct);
            ha = $urandom % NL; hb = $urandom % NL; hd = $urandom % NL;
        end
        in_valid = hold; in_is_load = h_ld;
        in_src_a = 5'(ha); in_src_b = 5'(hb); in_dst = 5'(hd);
        rd_done_valid = (refq.size() > 0);
        dtag = rd_done_valid ? refq.pop_front() : 0;
        rd_done_tag = 6'(dtag);
        ld_ret_valid = (pendq.size() > 0) && (($urandom % 100) < ret_pct);
        rtag = ld_ret_valid ? pendq.pop_front() : 0;
        ld_ret_tag = 6'(rtag);
        #1;
        ma = mmap[ha]; mb = mmap[hb]; md = mmap[hd];
        pend_hit = pend[ma] || pend[mb] || (!h_ld && pend[md]);
        exp_st = hold && (pend_hit || (h_ld && flq.size() == 0));
        if (exp_st && pend_hit)      chk("R6 stall on awaited data", stall, 1);
        else if (exp_st)             chk("R8 stall on empty free list", stall, 1);
        else if (was_stalled)        chk("R7 release after return", stall, 0);
        else                         chk("R6 no stall", stall, 0);
        acc = hold && !exp_st;
        rel = (prq.size() > 0) && (cnt[prq[0]] == 0) && !pend[prq[0]];
        exp_ov = acc;
        newp = md;
        if (acc && h_ld) newp = flq.pop_front();
        if (rel) begin
            int r = prq.pop_front();
            flq.push_back(r);
            reused[r] = 1;
        end
        if (acc) begin
            exp_pa = ma; exp_pb = mb; exp_pd = newp;
            lab_a = h_ld ? "R3 load source" : "R1 mapped source";
            lab_d = h_ld ? (reused[newp] ? "R5 R10 reclaimed name" : "R2 free-list head")
                         : "R4 mapped destination";
            cnt[ma]++; cnt[mb]++; refq.push_back(ma); refq.push_back(mb);
            if (!h_ld) begin cnt[md]++; refq.push_back(md); end
            else begin
                prq.push_back(md);
                mmap[hd] = newp;
                pend[newp] = 1;
                pendq.push_back(newp);
            end
        end
        if (rd_done_valid) cnt[dtag]--;
        if (ld_ret_valid) pend[rtag] = 0;
        was_stalled = exp_st;
        if (acc) hold = 0;
    endtask

    task automatic issue(input bit ld, input int a, input int b, input int d, input int tries);
        hold = 1; h_ld = ld; ha = a; hb = b; hd = d;
        for (int t = 0; t < tries && hold; t++) step(0);
    endtask

    task automatic finish_hold();
        while (hold) step(0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(0);
        // R1: identity map over every logical register.
        for (int i = 0; i < NL; i++) issue(0, i, NL - 1 - i, i, 50);
        repeat (100) step(0);
        // R3: load reading its own destination, then R6/R7 on its result.
        ret_pct = 0;
        issue(1, 5, 5, 5, 50);
        issue(0, 5, 0, 1, 4);
        ret_pct = 100;
        finish_hold();
        repeat (60) step(0);
        // R8: chain of loads to one register with no data returned.
        ret_pct = 0;
        for (int k = 0; k < 10; k++) issue(1, 0, 0, 20, 40);
        ret_pct = 100;
        finish_hold();
        repeat (60) step(0);
        // Random mixes: balanced, then load-heavy with slow returns.
        load_pct = 40; ret_pct = 30;
        repeat (4000) step(1);
        load_pct = 85; ret_pct = 10;
        repeat (3000) step(1);
        ret_pct = 100;
        finish_hold();
        repeat (80) step(0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule